// File: doc/BRIEF.md
# Triggered Pre/Post Window Capture Controller

This block runs the acquisition of one sampling channel. Once armed, it writes every incoming converter sample into a circular window memory and wraps around without end. It keeps doing so until an external discharge pulse arrives. It then writes a programmed number of further samples and stops. The memory is left holding the zone before the discharge and the zone after it.

The address of the first post-trigger sample is latched. When acquisition has stopped, a readout phase returns the window in chronological order, oldest pre-trigger sample first. A system with several channels uses one instance per channel. Each instance has its own memory, automaton and status.

The pre-trigger length `preLen` and the post-trigger length `postLen` are inputs. They must stay constant from arming to the end of readout. Their sum must not exceed the memory depth.

Top module: `trig_window_capture`

## Requirements
- R1: After reset `stateOut` is 0 (IDLE). The state codes are IDLE=0, FILLING=1, READY=2, POST=3, DONE=4, READOUT=5. A one-cycle `arm` is accepted only in IDLE or DONE. It moves the block to FILLING on the next edge and resets the write address and the fill count to 0. In every other state `arm` has no effect.
- R2: In FILLING, READY and POST (while the remaining post count is non-zero), each cycle with `sampleValid` high writes `sampleData` at the write address. The write address then increments modulo the depth. No sample is written in IDLE, DONE or READOUT.
- R3: FILLING moves to READY on the first edge at which the count of samples written since arming is at least `preLen`. A trigger edge seen during FILLING is ignored.
- R4: `trigIn` passes through a two-stage synchroniser and an edge detector. A level driven high just after a clock edge is acted on at the third rising edge. Only a rising edge detected in READY is accepted, and the block moves to POST. Edges in IDLE, FILLING, POST, DONE or READOUT are ignored, and so is a level that was already high on entry to READY.
- R5: On acceptance, `trigAddr` takes the address at which the next sample will be written. This includes the effect of a sample written in the accepting cycle. `trigAddr` changes at no other time.
- R6: In POST, exactly `postLen` further samples are written. On the edge after the count reaches zero the block enters DONE, and no further sample is written. `done` is high exactly while in DONE.
- R7: A `readStart` in DONE moves the block to READOUT. The read address starts at (`trigAddr` - `preLen`) modulo the depth, and `preLen`+`postLen` samples remain. While samples remain, `rdValid` is high and `rdData` shows the current sample. Each cycle with `rdNext` high advances to the next address. The samples come out in the order they were written. When none remain, the block returns to IDLE on the next edge.
- R8: `readStart` outside DONE, and `rdNext` while `rdValid` is low, have no effect on the state or on the data presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start acquisition (one-cycle pulse) |
| preLen | input | ADDR_W+1 | Pre-trigger sample count |
| postLen | input | ADDR_W+1 | Post-trigger sample count |
| sampleValid | input | 1 | A new converter sample is present |
| sampleData | input | DATA_W | Converter sample |
| trigIn | input | 1 | Asynchronous discharge trigger |
| readStart | input | 1 | Begin offline readout (pulse, DONE only) |
| rdNext | input | 1 | Advance to the next readout sample |
| stateOut | output | 3 | Automaton state code |
| done | output | 1 | Acquisition finished |
| trigAddr | output | ADDR_W | Latched address of first post-trigger sample |
| rdValid | output | 1 | Readout sample valid |
| rdData | output | DATA_W | Readout sample |

## Verification
The assertions take the configuration to be legal: `preLen`+`postLen` no larger than the depth, and both held steady for the whole of a run. Under those conditions the latched trigger address, the write gating and the readout flag relate as claimed. The stimulus changes the lengths only while the block is idle or done, and it keeps every run within the depth. It still drives `trigIn` freely and asynchronously, including edges during filling, during the post-trigger tail and in idle. Its runs include a window that wraps the memory several times under gapped sample strobes, and a zero-length window.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_FILL    = 3'd1,
    S_READY   = 3'd2,
    S_POST    = 3'd3,
    S_DONE    = 3'd4,
    S_READOUT = 3'd5
  } capState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic addrClr;
    logic wrEn;
    logic trigLatch;
    logic rdLoad;
    logic rdStep;
  } capCtl_t;

endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            arm,
  input  logic [ADDR_W:0] preLen,
  input  logic [ADDR_W:0] postLen,
  input  logic            sampleValid,
  input  logic            trigIn,
  input  logic            readStart,
  input  logic            rdNext,
  output capState_e       state,
  output capCtl_t         ctl,
  output logic            rdValid
);
  localparam int CNT_W = ADDR_W + 1;

  capState_e        nextState;
  logic [2:0]       trigSync;
  logic             trigRise;
  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] postCnt;
  logic [CNT_W-1:0] rdLeft;

  assign trigRise = trigSync[1] & ~trigSync[2];
  assign rdValid  = (state == S_READOUT) && (rdLeft != '0);

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      S_IDLE: begin
        if (arm) begin
          ctl.addrClr = 1'b1;
          nextState   = S_FILL;
        end
      end
      S_FILL: begin
        ctl.wrEn = sampleValid;
        if (fillCnt >= preLen) nextState = S_READY;
      end
      S_READY: begin
        ctl.wrEn = sampleValid;
        if (trigRise) begin
          ctl.trigLatch = 1'b1;
          nextState     = S_POST;
        end
      end
      S_POST: begin
        if (postCnt == '0) nextState = S_DONE;
        else ctl.wrEn = sampleValid;
      end
      S_DONE: begin
        if (arm) begin
          ctl.addrClr = 1'b1;
          nextState   = S_FILL;
        end else if (readStart) begin
          ctl.rdLoad = 1'b1;
          nextState  = S_READOUT;
        end
      end
      S_READOUT: begin
        if (rdLeft == '0) nextState = S_IDLE;
        else ctl.rdStep = rdNext;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      trigSync <= '0;
      fillCnt  <= '0;
      postCnt  <= '0;
      rdLeft   <= '0;
    end else begin
      state    <= nextState;
      trigSync <= {trigSync[1:0], trigIn};
      if (ctl.addrClr)
        fillCnt <= '0;
      else if (state == S_FILL && sampleValid && fillCnt != '1)
        fillCnt <= fillCnt + 1'b1;
      if (ctl.trigLatch)
        postCnt <= postLen;
      else if (state == S_POST && ctl.wrEn)
        postCnt <= postCnt - 1'b1;
      if (ctl.rdLoad)
        rdLeft <= preLen + postLen;
      else if (ctl.rdStep)
        rdLeft <= rdLeft - 1'b1;
    end
  end

endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  capCtl_t           ctl,
  input  logic [ADDR_W-1:0] preLow,
  input  logic [DATA_W-1:0] sampleData,
  output logic [ADDR_W-1:0] trigAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] winMem [DEPTH];
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) winMem[wrAddr] <= sampleData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr   <= '0;
      trigAddr <= '0;
      rdAddr   <= '0;
    end else begin
      if (ctl.addrClr)   wrAddr <= '0;
      else if (ctl.wrEn) wrAddr <= wrAddr + 1'b1;
      if (ctl.trigLatch) trigAddr <= wrAddr + ADDR_W'(ctl.wrEn);
      if (ctl.rdLoad)      rdAddr <= trigAddr - preLow;
      else if (ctl.rdStep) rdAddr <= rdAddr + 1'b1;
    end
  end

  assign rdData = winMem[rdAddr];

endmodule

// File: rtl/trig_window_capture.sv
module trig_window_capture
  import cap_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arm,
  input  logic [ADDR_W:0]   preLen,
  input  logic [ADDR_W:0]   postLen,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              trigIn,
  input  logic              readStart,
  input  logic              rdNext,
  output logic [2:0]        stateOut,
  output logic              done,
  output logic [ADDR_W-1:0] trigAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  capState_e state;
  capCtl_t   ctl;

  cap_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .arm(arm), .preLen(preLen), .postLen(postLen),
    .sampleValid(sampleValid), .trigIn(trigIn), .readStart(readStart),
    .rdNext(rdNext), .state(state), .ctl(ctl), .rdValid(rdValid)
  );

  cap_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .preLow(preLen[ADDR_W-1:0]),
    .sampleData(sampleData), .trigAddr(trigAddr), .rdData(rdData)
  );

  assign stateOut = state;
  assign done     = (state == S_DONE);

endmodule

// File: rtl/cap_checker.sv
module cap_checker
  import cap_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input capState_e         state,
  input capCtl_t           ctl,
  input logic [ADDR_W-1:0] trigAddr,
  input logic              rdValid
);
  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    state inside {S_IDLE, S_FILL, S_READY, S_POST, S_DONE, S_READOUT});

  // R2
  no_idle_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE || state == S_DONE || state == S_READOUT) |-> !ctl.wrEn);

  // R3
  no_early_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FILL) |=> (state != S_POST));

  // R5
  trig_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_READY) |=> $stable(trigAddr));

  // R6
  post_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_POST) |=> (state == S_POST || state == S_DONE));

  // R7
  rd_valid_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (state == S_READOUT));

endmodule

bind trig_window_capture cap_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .state(state), .ctl(ctl),
  .trigAddr(trigAddr), .rdValid(rdValid)
);

// File: tb/tb_trig_window_capture.sv
`timescale 1ns/1ps
module tb_trig_window_capture;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 12;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DMASK  = (1 << DATA_W) - 1;

  logic clk = 0, rstN = 0, arm = 0, sampleValid = 0, trigIn = 0;
  logic readStart = 0, rdNext = 0;
  logic [ADDR_W:0] preLen = 0, postLen = 0;
  logic [DATA_W-1:0] sampleData = 0;
  logic [2:0] stateOut;
  logic done, rdValid;
  logic [ADDR_W-1:0] trigAddr;
  logic [DATA_W-1:0] rdData;

  int checks = 0, errors = 0;

  trig_window_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mSt = 0, mWa = 0, mFill = 0, mPost = 0, mTa = 0, mRa = 0, mLeft = 0, mLast = 0;
  bit mS0 = 0, mS1 = 0, mS2 = 0;
  int mMem [DEPTH];

  function automatic void mWrite();
    mMem[mWa] = int'(sampleData);
    mLast = int'(sampleData);
    mWa = (mWa + 1) % DEPTH;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mWa = 0; mFill = 0; mPost = 0; mTa = 0; mRa = 0; mLeft = 0;
      mS0 = 0; mS1 = 0; mS2 = 0;
    end else begin
      bit rise, go;
      rise = mS1 && !mS2;
      mS2 = mS1; mS1 = mS0; mS0 = trigIn;
      case (mSt)
        0: if (arm) begin mSt = 1; mWa = 0; mFill = 0; end
        1: begin
          go = (mFill >= int'(preLen));
          if (sampleValid) begin mWrite(); mFill++; end
          if (go) mSt = 2;
        end
        2: begin
          if (sampleValid) mWrite();
          if (rise) begin mTa = mWa; mPost = int'(postLen); mSt = 3; end
        end
        3: begin
          if (mPost == 0) mSt = 4;
          else if (sampleValid) begin mWrite(); mPost--; end
        end
        4: begin
          if (arm) begin mSt = 1; mWa = 0; mFill = 0; end
          else if (readStart) begin
            mRa = ((mTa - int'(preLen)) % DEPTH + DEPTH) % DEPTH;
            mLeft = int'(preLen) + int'(postLen);
            mSt = 5;
          end
        end
        default: begin
          if (mLeft == 0) mSt = 0;
          else if (rdNext) begin mRa = (mRa + 1) % DEPTH; mLeft--; end
        end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk(int'(stateOut) == mSt, "R1 state", int'(stateOut), mSt);
      chk(done == (mSt == 4), "R6 done", int'(done), int'(mSt == 4));
      chk(int'(trigAddr) == mTa, "R5 trigAddr", int'(trigAddr), mTa);
      chk(rdValid == (mSt == 5 && mLeft != 0), "R7 rdValid", int'(rdValid),
          int'(mSt == 5 && mLeft != 0));
      if (rdValid && mSt == 5)
        chk(int'(rdData) == mMem[mRa], "R7 rdData", int'(rdData), mMem[mRa]);
    end
  end

  // ---------------- sample source ----------------
  bit genOn = 0, gapMode = 0;
  int seq = 0, gapCnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      sampleValid = genOn && (!gapMode || (gapCnt % 3 != 0));
      if (sampleValid) begin
        sampleData = DATA_W'(seq & DMASK);
        seq++;
      end
      gapCnt++;
    end
  end

  // ---------------- helpers ----------------
  task automatic waitState(input int s, input string tag);
    for (int i = 0; i < 3000; i++) begin
      if (int'(stateOut) == s) return;
      @(negedge clk);
    end
    chk(0, tag, int'(stateOut), s);
  endtask

  task automatic pulseArm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic readAll(input int expN, input bit toggle, input string tag);
    int n = 0, prev = 0;
    bit phase = 1;
    @(negedge clk); readStart = 1;
    @(negedge clk); readStart = 0;
    chk(stateOut == 3'd5, {tag, " R7 enter readout"}, int'(stateOut), 5);
    for (int g = 0; g < 500 && stateOut == 3'd5; g++) begin
      if (rdValid && (!toggle || phase)) begin
        if (n > 0)
          chk(int'(rdData) == ((prev + 1) & DMASK), {tag, " R7 order"},
              int'(rdData), (prev + 1) & DMASK);
        prev = int'(rdData);
        n++;
        rdNext = 1;
      end else rdNext = 0;
      phase = !phase;
      @(negedge clk);
    end
    rdNext = 0;
    chk(n == expN, {tag, " R7 count"}, n, expN);
    if (n > 0) chk(prev == mLast, {tag, " R7 last sample"}, prev, mLast);
    chk(stateOut == 3'd0, {tag, " R7 back to idle"}, int'(stateOut), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [ADDR_W-1:0] taHold;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(stateOut == 3'd0, "R1 reset state", int'(stateOut), 0);
    chk(!done && !rdValid, "R1 reset flags", int'(done || rdValid), 0);

    // R4: trigger while idle is ignored
    trigIn = 1; repeat (3) @(negedge clk); trigIn = 0; repeat (4) @(negedge clk);
    chk(stateOut == 3'd0, "R4 idle trigger ignored", int'(stateOut), 0);
    // R8: readStart outside DONE
    readStart = 1; @(negedge clk); readStart = 0; @(negedge clk);
    chk(stateOut == 3'd0, "R8 readStart in idle", int'(stateOut), 0);

    // Run A: continuous samples, pre 8, post 8
    preLen = 8; postLen = 8; genOn = 1; gapMode = 0;
    pulseArm();
    chk(stateOut == 3'd1, "R1 arm to filling", int'(stateOut), 1);
    trigIn = 1; repeat (3) @(negedge clk); trigIn = 0;   // R3 early edge
    chk(stateOut == 3'd1, "R3 early trigger ignored", int'(stateOut), 1);
    waitState(2, "R3 reach ready");
    readStart = 1; @(negedge clk); readStart = 0; @(negedge clk);
    chk(stateOut == 3'd2, "R8 readStart in ready", int'(stateOut), 2);
    repeat (10) @(negedge clk);
    trigIn = 1;
    @(negedge clk); @(negedge clk);
    chk(stateOut == 3'd2, "R4 latency not yet", int'(stateOut), 2);
    @(negedge clk);
    chk(stateOut == 3'd3, "R4 trigger accepted", int'(stateOut), 3);
    waitState(4, "R6 reach done");
    chk(done == 1'b1, "R6 done flag", int'(done), 1);
    readAll(16, 0, "runA");

    // Run B: gapped samples, wraps memory, pre 20, post 40
    trigIn = 0; preLen = 20; postLen = 40; gapMode = 1;
    pulseArm();
    repeat (150) @(negedge clk);
    trigIn = 1;
    waitState(3, "R4 runB post");
    taHold = trigAddr;
    repeat (2) @(negedge clk); trigIn = 0; repeat (2) @(negedge clk); trigIn = 1;
    repeat (5) @(negedge clk);
    chk(trigAddr == taHold, "R4 second edge ignored", int'(trigAddr), int'(taHold));
    chk(stateOut == 3'd3, "R4 still in post", int'(stateOut), 3);
    waitState(4, "R6 runB done");
    readAll(60, 1, "runB");

    // Run C: zero-length window and re-arm from DONE
    trigIn = 0; preLen = 0; postLen = 0; gapMode = 0;
    pulseArm();
    waitState(2, "R3 zero pre ready");
    trigIn = 1;
    waitState(4, "R6 zero post done");
    trigIn = 0;
    pulseArm();
    chk(stateOut == 3'd1, "R1 re-arm from done", int'(stateOut), 1);
    waitState(2, "R3 runC ready");
    trigIn = 1;
    waitState(4, "R6 runC done");
    readAll(0, 0, "runC");
    genOn = 0;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule